// File: doc/BRIEF.md
# MAC Result Saturation and Flag Unit

This unit sits between the multiply-accumulate datapath and the accumulator write port. It takes the raw 36-bit result, which is a 4-bit extension above a 16-bit high word and a 16-bit low word. When the saturation mode is on, it clamps the result to the largest positive or largest negative 32-bit fraction. It also produces the carry, negative, zero and overflow flags from the value that is actually stored.

The clamp decision looks at three result bits only: bit 35 (the top of the extension), bit 32 (the bottom of the extension) and bit 31 (the top of the high word). A class input from the decoder marks the operations that must never be clamped. These are shifts, rotates, logical operations and the integer and mixed-sign multiplies. A flag-width mode bit moves the reference point of the flags from the full 36-bit value to the low 32 bits.

The unit is combinational. A parameter can add one output register, which is on by default. That register has a synchronous active-high reset.

Top module: `mac_post_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every registered output is cleared to zero on that edge.
- R2: With `sa_i` low, `res_o` equals `raw_i` and `sat_o` is 0.
- R3: With `no_sat_i` high, `res_o` equals `raw_i` and `sat_o` is 0, whatever the value of `sa_i`.
- R4: With `sa_i` high and `no_sat_i` low, bits {35,32,31} of `raw_i` equal to 001, 010 or 011 make `res_o` = 36'h0_7FFF_FFFF and set `sat_o` to 1.
- R5: With `sa_i` high and `no_sat_i` low, bits {35,32,31} equal to 100, 101 or 110 make `res_o` = 36'h F_8000_0000 and set `sat_o` to 1.
- R6: With `sa_i` high and `no_sat_i` low, bits {35,32,31} equal to 000 or 111 leave `res_o` = `raw_i` with `sat_o` 0. `sat_o` is high only when `res_o` differs from `raw_i`.
- R7: With `cc_i` low, N is `res_o[35]`, Z is 1 when all 36 bits are zero, C is `carry_hi_i` and V is `ovf_i`.
- R8: With `cc_i` high, N is `res_o[31]`, Z is 1 when `res_o[31:0]` is zero, C is `carry_lo_i`, and V is `ovf_i` OR (bits 35:31 of `res_o` not all equal).
- R9: The flags are derived from the stored (possibly clamped) value, not from `raw_i`.
- R10: With the output register enabled (default), every output reflects the inputs of the previous clock edge: latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_i | input | 36 | Raw MAC result {ext[3:0], high word, low word} |
| carry_hi_i | input | 1 | Carry out of bit 35 from the MAC adder |
| carry_lo_i | input | 1 | Carry out of bit 31 from the MAC adder |
| ovf_i | input | 1 | Signed overflow of the 36-bit MAC operation |
| sa_i | input | 1 | Saturation mode enable |
| cc_i | input | 1 | Flag width select: 1 = 32-bit, 0 = 36-bit |
| no_sat_i | input | 1 | Operation class exempt from saturation |
| res_o | output | 36 | Value to store in the accumulator |
| sat_o | output | 1 | Result was clamped |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |

## Verification
Every result, meaning the stored value, the clamp flag and all four condition flags, is due exactly one clock edge after its inputs are applied. The driver applies inputs on the falling edge. It pushes the expected item into a queue at that moment. A marker captured on the next rising edge tells the monitor to pop and compare on the falling edge that follows, so each comparison takes place half a cycle after the register has updated. The reset check samples during reset, on a falling edge, after the clearing edge.

// File: rtl/mac_post_pkg.sv
package mac_post_pkg;
  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_POS  = 2'd1,
    CLAMP_NEG  = 2'd2
  } clamp_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
  } flags_t;
endpackage

// File: rtl/mac_sat_stage.sv
module mac_sat_stage
  import mac_post_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic [EXT_W+2*WORD_W-1:0] raw_i,
  input  logic                      sa_i,
  input  logic                      no_sat_i,
  output logic [EXT_W+2*WORD_W-1:0] val_o,
  output clamp_e                    kind_o
);
  localparam int TOT_W  = EXT_W + 2*WORD_W;
  localparam int TOP_B  = TOT_W - 1;
  localparam int EXT0_B = 2*WORD_W;
  localparam int MSP_B  = 2*WORD_W - 1;
  localparam logic [TOT_W-1:0] MAX_POS = {{(EXT_W+1){1'b0}}, {(2*WORD_W-1){1'b1}}};
  localparam logic [TOT_W-1:0] MAX_NEG = {{(EXT_W+1){1'b1}}, {(2*WORD_W-1){1'b0}}};

  logic [2:0] probe;
  assign probe = {raw_i[TOP_B], raw_i[EXT0_B], raw_i[MSP_B]};

  always_comb begin
    kind_o = CLAMP_NONE;
    if (sa_i && !no_sat_i) begin
      if (!probe[2] && (probe[1:0] != 2'b00))      kind_o = CLAMP_POS;
      else if (probe[2] && (probe[1:0] != 2'b11))  kind_o = CLAMP_NEG;
    end
  end

  always_comb begin
    unique case (kind_o)
      CLAMP_POS: val_o = MAX_POS;
      CLAMP_NEG: val_o = MAX_NEG;
      default:   val_o = raw_i;
    endcase
  end

  // R4 / R5: a clamped value always fits the 32-bit signed range
  always_comb begin
    if (kind_o != CLAMP_NONE)
      assert_clamp_fits_R4: assert (&val_o[TOP_B:MSP_B] || ~|val_o[TOP_B:MSP_B]);
  end
endmodule

// File: rtl/mac_flag_stage.sv
module mac_flag_stage
  import mac_post_pkg::*;
#(
  parameter int EXT_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic [EXT_W+2*WORD_W-1:0] val_i,
  input  logic                      cc_i,
  input  logic                      carry_hi_i,
  input  logic                      carry_lo_i,
  input  logic                      ovf_i,
  output flags_t                    flags_o
);
  localparam int TOT_W = EXT_W + 2*WORD_W;
  localparam int LO_W  = 2*WORD_W;

  logic wide_n, wide_z, narrow_n, narrow_z, narrow_v;

  assign wide_n   = val_i[TOT_W-1];
  assign wide_z   = ~|val_i;
  assign narrow_n = val_i[LO_W-1];
  assign narrow_z = ~|val_i[LO_W-1:0];
  // the value exceeds the 32-bit signed range when the bits above bit 31 do not all copy it
  assign narrow_v = ~(&val_i[TOT_W-1:LO_W-1] | ~|val_i[TOT_W-1:LO_W-1]);

  always_comb begin
    if (cc_i) begin
      flags_o.n = narrow_n;
      flags_o.z = narrow_z;
      flags_o.c = carry_lo_i;
      flags_o.v = ovf_i | narrow_v;
    end else begin
      flags_o.n = wide_n;
      flags_o.z = wide_z;
      flags_o.c = carry_hi_i;
      flags_o.v = ovf_i;
    end
  end

  // R8: a narrow-mode zero never reports negative
  always_comb begin
    if (cc_i && flags_o.z)
      assert_narrow_zero_pos_R8: assert (!flags_o.n);
  end
endmodule

// File: rtl/mac_post_unit.sv
module mac_post_unit
  import mac_post_pkg::*;
#(
  parameter int EXT_W   = 4,
  parameter int WORD_W  = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [EXT_W+2*WORD_W-1:0] raw_i,
  input  logic                      carry_hi_i,
  input  logic                      carry_lo_i,
  input  logic                      ovf_i,
  input  logic                      sa_i,
  input  logic                      cc_i,
  input  logic                      no_sat_i,
  output logic [EXT_W+2*WORD_W-1:0] res_o,
  output logic                      sat_o,
  output logic                      flag_c_o,
  output logic                      flag_v_o,
  output logic                      flag_z_o,
  output logic                      flag_n_o
);
  localparam int TOT_W = EXT_W + 2*WORD_W;
  localparam int LO_W  = 2*WORD_W;

  logic [TOT_W-1:0] val_c;
  clamp_e           kind_c;
  flags_t           flags_c;

  mac_sat_stage #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_sat (
    .raw_i    (raw_i),
    .sa_i     (sa_i),
    .no_sat_i (no_sat_i),
    .val_o    (val_c),
    .kind_o   (kind_c)
  );

  mac_flag_stage #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_flag (
    .val_i      (val_c),
    .cc_i       (cc_i),
    .carry_hi_i (carry_hi_i),
    .carry_lo_i (carry_lo_i),
    .ovf_i      (ovf_i),
    .flags_o    (flags_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [TOT_W-1:0] res_q;
      logic             sat_q;
      flags_t           flags_q;
      logic             armed_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          res_q   <= '0;
          sat_q   <= 1'b0;
          flags_q <= '0;
          armed_q <= 1'b0;
        end else begin
          res_q   <= val_c;
          sat_q   <= (kind_c != CLAMP_NONE);
          flags_q <= flags_c;
          armed_q <= 1'b1;
        end
      end

      assign res_o    = res_q;
      assign sat_o    = sat_q;
      assign flag_c_o = flags_q.c;
      assign flag_v_o = flags_q.v;
      assign flag_z_o = flags_q.z;
      assign flag_n_o = flags_q.n;

      assert_sa_off_pass_R2: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(sa_i) |-> (res_o == $past(raw_i)) && !sat_o);
      assert_exempt_pass_R3: assert property (@(posedge clk) disable iff (rst)
        armed_q && $past(no_sat_i) |-> (res_o == $past(raw_i)) && !sat_o);
      assert_sat_differs_R6: assert property (@(posedge clk) disable iff (rst)
        armed_q && sat_o |-> res_o != $past(raw_i));
      assert_wide_zero_R7: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(cc_i) |-> flag_z_o == (res_o == '0));
      assert_narrow_neg_R8: assert property (@(posedge clk) disable iff (rst)
        armed_q && $past(cc_i) |-> flag_n_o == res_o[LO_W-1]);
    end else begin : g_comb
      assign res_o    = val_c;
      assign sat_o    = (kind_c != CLAMP_NONE);
      assign flag_c_o = flags_c.c;
      assign flag_v_o = flags_c.v;
      assign flag_z_o = flags_c.z;
      assign flag_n_o = flags_c.n;
    end
  endgenerate
endmodule

// File: tb/test_mac_post_unit.sv
`timescale 1ns/1ps
module test_mac_post_unit;
  typedef struct {
    logic [35:0] res;
    logic        sat, c, v, z, n;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [35:0] raw_i = '0;
  logic        carry_hi_i = 1'b0, carry_lo_i = 1'b0, ovf_i = 1'b0;
  logic        sa_i = 1'b0, cc_i = 1'b0, no_sat_i = 1'b0;
  logic [35:0] res_o;
  logic        sat_o, flag_c_o, flag_v_o, flag_z_o, flag_n_o;

  int    errors = 0;
  int    checks = 0;
  item_t sb_q[$];
  logic  drv_flag = 1'b0;
  logic  pend = 1'b0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  mac_post_unit i_mac_post_unit (
    .clk(clk), .rst(rst), .raw_i(raw_i), .carry_hi_i(carry_hi_i),
    .carry_lo_i(carry_lo_i), .ovf_i(ovf_i), .sa_i(sa_i), .cc_i(cc_i),
    .no_sat_i(no_sat_i), .res_o(res_o), .sat_o(sat_o), .flag_c_o(flag_c_o),
    .flag_v_o(flag_v_o), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o)
  );

  function automatic item_t model(logic [35:0] raw, logic sa, logic cc, logic ns,
                                  logic chi, logic clo, logic ov, string tag);
    item_t e;
    logic [2:0] p;
    p = {raw[35], raw[32], raw[31]};
    e.res = raw; e.sat = 1'b0; e.tag = tag;
    if (sa && !ns) begin
      if (p == 3'b001 || p == 3'b010 || p == 3'b011) begin e.res = 36'h0_7FFF_FFFF; e.sat = 1'b1; end
      if (p == 3'b100 || p == 3'b101 || p == 3'b110) begin e.res = 36'hF_8000_0000; e.sat = 1'b1; end
    end
    if (cc) begin
      e.n = e.res[31];
      e.z = (e.res[31:0] == 32'd0);
      e.c = clo;
      e.v = ov | !((e.res[35:31] == 5'b11111) || (e.res[35:31] == 5'b00000));
    end else begin
      e.n = e.res[35];
      e.z = (e.res == 36'd0);
      e.c = chi;
      e.v = ov;
    end
    return e;
  endfunction

  task automatic drive(logic [35:0] raw, logic sa, logic cc, logic ns,
                       logic chi, logic clo, logic ov, string tag);
    @(negedge clk);
    raw_i = raw; sa_i = sa; cc_i = cc; no_sat_i = ns;
    carry_hi_i = chi; carry_lo_i = clo; ovf_i = ov;
    drv_flag = 1'b1;
    sb_q.push_back(model(raw, sa, cc, ns, chi, clo, ov, tag));
  endtask

  always @(posedge clk) pend <= drv_flag;

  always @(negedge clk) begin
    if (pend && sb_q.size() > 0) begin
      item_t e;
      e = sb_q.pop_front();
      checks++;
      if (res_o !== e.res || sat_o !== e.sat || flag_c_o !== e.c ||
          flag_v_o !== e.v || flag_z_o !== e.z || flag_n_o !== e.n) begin
        errors++;
        $display("FAIL %s: got res=%h sat=%b cvzn=%b%b%b%b expected res=%h sat=%b cvzn=%b%b%b%b",
                 e.tag, res_o, sat_o, flag_c_o, flag_v_o, flag_z_o, flag_n_o,
                 e.res, e.sat, e.c, e.v, e.z, e.n);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: drive nonzero inputs during reset, outputs must stay cleared
    raw_i = 36'hF_FFFF_FFFF; carry_hi_i = 1'b1; ovf_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (res_o !== '0 || sat_o !== 1'b0 || {flag_c_o, flag_v_o, flag_z_o, flag_n_o} !== 4'b0) begin
      errors++;
      $display("FAIL R1: got res=%h sat=%b flags=%b%b%b%b expected all zero",
               res_o, sat_o, flag_c_o, flag_v_o, flag_z_o, flag_n_o);
    end
    rst = 1'b0;

    // R2: saturation off
    drive(36'h0_9000_0000, 0, 0, 0, 0, 0, 0, "R2");
    drive(36'h8_0000_0000, 0, 0, 0, 1, 0, 0, "R2");
    // R4: positive clamp patterns
    drive(36'h0_9000_0000, 1, 0, 0, 0, 0, 0, "R4");
    drive(36'h1_0000_0000, 1, 0, 0, 0, 0, 0, "R4");
    drive(36'h1_8000_0001, 1, 0, 0, 0, 0, 0, "R4");
    // R5: negative clamp patterns
    drive(36'h8_0000_0000, 1, 0, 0, 0, 0, 0, "R5");
    drive(36'h8_8000_0000, 1, 0, 0, 0, 0, 0, "R5");
    drive(36'hF_0000_0000, 1, 0, 0, 0, 0, 0, "R5");
    // R6: in-range patterns pass
    drive(36'h0_1234_5678, 1, 0, 0, 0, 0, 0, "R6");
    drive(36'hF_8000_1234, 1, 0, 0, 0, 0, 0, "R6");
    // R3: exempt class
    drive(36'h0_9000_0000, 1, 0, 1, 0, 0, 0, "R3");
    drive(36'h8_0000_0000, 1, 1, 1, 0, 0, 0, "R3");
    // R7: wide flags
    drive(36'h0_0000_0000, 0, 0, 0, 1, 0, 1, "R7");
    drive(36'h1_0000_0000, 0, 0, 0, 0, 1, 0, "R7");
    // R8: narrow flags
    drive(36'h1_0000_0000, 0, 1, 0, 1, 0, 0, "R8");
    drive(36'h0_8000_0000, 0, 1, 0, 0, 1, 0, "R8");
    drive(36'hF_FFFF_FFFF, 0, 1, 0, 0, 0, 1, "R8");
    // R9: flags follow clamped value
    drive(36'h8_0000_0000, 1, 1, 0, 0, 0, 0, "R9");
    drive(36'h1_0000_0000, 1, 0, 0, 0, 0, 0, "R9");
    // R10: back-to-back varying inputs, each due one cycle later
    for (int k = 0; k < 300; k++) begin
      logic [35:0] r;
      r = {$urandom(), $urandom()};
      drive(r, 1'($urandom()), 1'($urandom()), 1'($urandom() % 4 == 0),
            1'($urandom()), 1'($urandom()), 1'($urandom()), "R10");
    end
    @(negedge clk);
    drv_flag = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R10: got %0d pending results expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule